// File: doc/BRIEF.md
# Programmable Three-Aspect Signal Sequencer

This block drives a single signal head with red, yellow and green lamps. It steps through red, then green, then yellow, then back to red. Each light stays on for a number of ticks taken from its own 6-bit field of an 18-bit dwell word. An external one-cycle tick pulse sets the time base, and the block counts a tick only while its run enable is high. Dropping the enable freezes the sequence at the exact point it reached. Raising it again carries on from there.

The dwell word is checked on every clock. If any field is zero, the sequencer goes at once to a fault state and raises its fault flag. In that state the red and green lamps are dark and the yellow lamp flashes, changing on each counted tick. The first counted tick that sees a fully valid dwell word returns the sequencer to red with a fresh count. The current phase is also given out as a 2-bit code, so the block can be observed.

Top module: `traffic_phaser`

## Requirements
- R1: A synchronous active-high reset puts the block into red (phase code 00) with fault low and the elapsed count cleared, so the first red lasts its full programmed dwell.
- R2: Phase codes are red=00, green=01, yellow=10, fault=11. In each of the three light phases exactly one lamp is on, and it is the lamp of that phase.
- R3: The dwell word is laid out as red in bits [17:12], green in bits [11:6] and yellow in bits [5:0]. A light phase lasts exactly as many counted ticks as its field holds (1 to 63).
- R4: The light order is red, then green, then yellow, then red again.
- R5: A tick counts only on a clock cycle where both run_en and tick are high. A tick pulse while run_en is low has no effect, and neither does run_en without a tick.
- R6: While run_en is low, the phase and the elapsed count are held. After run_en returns, the phase ends after only the ticks that were still left.
- R7: If any dwell field is zero in a light phase, the block enters the fault phase on the next clock edge, whatever run_en and tick are doing, and fault goes high.
- R8: In the fault phase, red and green are off. Yellow starts off on entry and toggles on each counted tick while the dwell word is still invalid.
- R9: Recovery from fault happens only on a counted tick that sees a valid dwell word. The block then enters red with the count cleared and fault low. A valid word without a counted tick leaves the block in fault.
- R10: If the dwell word is reprogrammed so that the current phase's field is at or below the ticks already counted, the next counted tick ends the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable; low freezes the sequence |
| tick | input | 1 | One-cycle time-base pulse |
| dwell_cfg | input | 18 | Dwell fields: red [17:12], green [11:6], yellow [5:0] |
| lamp_red | output | 1 | Red lamp drive |
| lamp_yellow | output | 1 | Yellow lamp drive (flashes in fault) |
| lamp_green | output | 1 | Green lamp drive |
| fault | output | 1 | High while in the fault phase |
| phase | output | 2 | Current phase code |

## Verification
The hardest case to reach from the ports is a pause partway through a phase followed by a correct resume. It is only visible through how many ticks the phase takes after run_en comes back. The stimulus gets there with a directed run that stops green after one of its two ticks, offers tick pulses while run_en is low and run_en without ticks, and then expects green to end on the very next counted tick. A second hard case is a dwell field shortened below the count already reached, which is also set up directly. Fault entry with run_en low, flashing, and recovery that waits for a counted tick are driven in order. Random dwell words with occasional zero fields then run against a cycle model kept in the bench.

// File: rtl/traffic_phaser.sv
module traffic_phaser #(
  parameter int FW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic            tick,
  input  logic [3*FW-1:0] dwell_cfg,
  output logic            lamp_red,
  output logic            lamp_yellow,
  output logic            lamp_green,
  output logic            fault,
  output logic [1:0]      phase
);

  typedef enum logic [1:0] {
    PH_RED   = 2'b00,
    PH_GREEN = 2'b01,
    PH_YEL   = 2'b10,
    PH_ERR   = 2'b11
  } phase_t;

  phase_t        st;
  logic [FW-1:0] cnt;
  logic          blink;

  logic [FW-1:0] dur_red, dur_green, dur_yel, dur_cur;
  logic [FW:0]   elapsed;
  logic          counted, cfg_bad, expired;

  assign dur_red   = dwell_cfg[3*FW-1:2*FW];
  assign dur_green = dwell_cfg[2*FW-1:FW];
  assign dur_yel   = dwell_cfg[FW-1:0];

  assign cfg_bad = (dur_red == '0) || (dur_green == '0) || (dur_yel == '0);
  assign counted = run_en & tick;

  always_comb begin
    case (st)
      PH_RED:   dur_cur = dur_red;
      PH_GREEN: dur_cur = dur_green;
      PH_YEL:   dur_cur = dur_yel;
      default:  dur_cur = '0;
    endcase
  end

  assign elapsed = {1'b0, cnt} + 1'b1;
  assign expired = elapsed >= {1'b0, dur_cur};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PH_RED;
      cnt   <= '0;
      blink <= 1'b0;
    end else if (st != PH_ERR && cfg_bad) begin
      st    <= PH_ERR;
      cnt   <= '0;
      blink <= 1'b0;
    end else if (st == PH_ERR) begin
      if (counted) begin
        if (cfg_bad) begin
          blink <= ~blink;
        end else begin
          st    <= PH_RED;
          cnt   <= '0;
          blink <= 1'b0;
        end
      end
    end else if (counted) begin
      if (expired) begin
        cnt <= '0;
        case (st)
          PH_RED:   st <= PH_GREEN;
          PH_GREEN: st <= PH_YEL;
          default:  st <= PH_RED;
        endcase
      end else begin
        cnt <= elapsed[FW-1:0];
      end
    end
  end

  assign lamp_red    = (st == PH_RED);
  assign lamp_green  = (st == PH_GREEN);
  assign lamp_yellow = (st == PH_YEL) || (st == PH_ERR && blink);
  assign fault       = (st == PH_ERR);
  assign phase       = st;

  p_lamp_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    (st != PH_ERR) |-> $countones({lamp_red, lamp_yellow, lamp_green}) == 1);

  p_err_dark_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!lamp_red && !lamp_green));

  p_bad_cfg_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> fault);

  p_pause_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!counted && !cfg_bad && st != PH_ERR) |=> ($stable(st) && $stable(cnt)));

  p_recover_r9: assert property (@(posedge clk) disable iff (rst)
    (fault && counted && !cfg_bad) |=> (phase == 2'b00 && cnt == '0 && !fault));

  p_blink_r8: assert property (@(posedge clk) disable iff (rst)
    (fault && counted && cfg_bad) |=> (fault && lamp_yellow != $past(lamp_yellow)));

endmodule

// File: tb/tb_traffic_phaser.sv
module tb_traffic_phaser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic tick = 1'b0;
  logic [17:0] dwell_cfg = '0;
  logic lamp_red, lamp_yellow, lamp_green, fault;
  logic [1:0] phase;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [1:0] m_st;
  int         m_cnt;
  logic       m_blink;

  always #5 clk = ~clk;

  traffic_phaser dut (
    .clk(clk), .rst(rst), .run_en(run_en), .tick(tick), .dwell_cfg(dwell_cfg),
    .lamp_red(lamp_red), .lamp_yellow(lamp_yellow), .lamp_green(lamp_green),
    .fault(fault), .phase(phase)
  );

  function automatic logic [17:0] mk(input int r, input int g, input int y);
    return {r[5:0], g[5:0], y[5:0]};
  endfunction

  function automatic int field_of(input logic [1:0] s, input logic [17:0] c);
    case (s)
      2'b00:   return int'(c[17:12]);
      2'b01:   return int'(c[11:6]);
      2'b10:   return int'(c[5:0]);
      default: return 0;
    endcase
  endfunction

  function automatic bit bad(input logic [17:0] c);
    return c[17:12] == 0 || c[11:6] == 0 || c[5:0] == 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input bit en, input bit tk, input logic [17:0] c);
    bit cnt_ok;
    cnt_ok = en && tk;
    if (m_st != 2'b11 && bad(c)) begin
      m_st = 2'b11; m_cnt = 0; m_blink = 0;
    end else if (m_st == 2'b11) begin
      if (cnt_ok) begin
        if (bad(c)) m_blink = ~m_blink;
        else begin m_st = 2'b00; m_cnt = 0; m_blink = 0; end
      end
    end else if (cnt_ok) begin
      if (m_cnt + 1 >= field_of(m_st, c)) begin
        m_cnt = 0;
        m_st = (m_st == 2'b00) ? 2'b01 : (m_st == 2'b01) ? 2'b10 : 2'b00;
      end else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic cyc(input bit en, input bit tk, input logic [17:0] c);
    logic [2:0] exp_l;
    @(negedge clk);
    run_en = en; tick = tk; dwell_cfg = c;
    model_step(en, tk, c);
    @(posedge clk);
    #1;
    exp_l = {m_st == 2'b00, (m_st == 2'b10) || (m_st == 2'b11 && m_blink), m_st == 2'b01};
    check(phase == m_st, "R2 phase code", phase, m_st);
    check({lamp_red, lamp_yellow, lamp_green} == exp_l, "R2 lamps", {lamp_red, lamp_yellow, lamp_green}, exp_l);
    check(fault == (m_st == 2'b11), "R7 fault flag", fault, m_st == 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [17:0] cv;
    void'($urandom(32'd1234));
    cv = mk(3, 2, 1);
    m_st = 2'b00; m_cnt = 0; m_blink = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    dwell_cfg = cv;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(phase == 2'b00 && lamp_red && !fault, "R1 reset state", phase, 0);

    cyc(1, 1, cv); cyc(1, 1, cv);
    check(phase == 2'b00, "R3 red holds for 3 ticks", phase, 0);
    cyc(1, 1, cv);
    check(phase == 2'b01, "R3 R4 red to green after 3 ticks", phase, 1);

    for (int i = 0; i < 3; i++) cyc(0, 1, cv);
    check(phase == 2'b01, "R5 tick without enable ignored", phase, 1);
    for (int i = 0; i < 3; i++) cyc(1, 0, cv);
    check(phase == 2'b01, "R5 enable without tick ignored", phase, 1);

    cyc(1, 1, cv);
    check(phase == 2'b01, "R6 green midway", phase, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, cv);
    check(phase == 2'b01, "R6 paused", phase, 1);
    cyc(1, 1, cv);
    check(phase == 2'b10, "R6 resumes with one tick left", phase, 2);
    cyc(1, 1, cv);
    check(phase == 2'b00, "R4 yellow to red", phase, 0);

    cyc(1, 1, cv); cyc(1, 1, cv);
    check(phase == 2'b00, "R10 red after 2 ticks", phase, 0);
    cyc(1, 1, mk(1, 2, 1));
    check(phase == 2'b01, "R10 shortened dwell ends phase", phase, 1);

    cyc(0, 0, mk(3, 0, 1));
    check(phase == 2'b11 && fault, "R7 zero field enters fault with enable low", phase, 3);
    check(!lamp_yellow && !lamp_red && !lamp_green, "R8 all dark on entry", lamp_yellow, 0);
    cyc(1, 1, mk(3, 0, 1));
    check(lamp_yellow == 1'b1, "R8 yellow toggles on", lamp_yellow, 1);
    cyc(1, 1, mk(3, 0, 1));
    check(lamp_yellow == 1'b0 && phase == 2'b11, "R8 R9 yellow toggles off, stays fault", lamp_yellow, 0);
    cyc(1, 0, cv);
    check(phase == 2'b11, "R9 valid word without tick stays fault", phase, 3);
    cyc(1, 1, cv);
    check(phase == 2'b00 && !fault && lamp_red, "R9 recovery into red", phase, 0);
    cyc(1, 1, cv); cyc(1, 1, cv);
    check(phase == 2'b00, "R9 count cleared on recovery", phase, 0);
    cyc(1, 1, cv);
    check(phase == 2'b01, "R9 full red dwell after recovery", phase, 1);

    for (int k = 0; k < 4000; k++) begin
      if (k % 150 == 0) begin
        int r, g, y;
        r = 1 + int'($urandom % 5);
        g = 1 + int'($urandom % 5);
        y = 1 + int'($urandom % 5);
        if ($urandom % 6 == 0) r = 0;
        if ($urandom % 8 == 0) y = 0;
        cv = mk(r, g, y);
      end
      cyc(($urandom % 5) != 0, ($urandom % 2) != 0, cv);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule